// File: doc/BRIEF.md
# Programmable Interrupt Request Front End

This block sits between a group of asynchronous interrupt request lines and the CPU. It synchronises each line and corrects the polarity of the single active-low line. It then turns each line into a pending bit, using either edge capture or level following as set by a per-line mode register. The unmasked pending bits are combined into one CPU interrupt output.

The CPU runs an acknowledge cycle by pulsing an acknowledge strobe. One cycle later the block returns the number of the lowest-numbered unmasked pending line and clears that line's captured edge. If the winning line was withdrawn before the acknowledge, the block returns the default line 7 instead. If nothing is pending at all, it also returns line 7.

A separate keyboard-style latch records rising edges on line 1. A read strobe at I/O address 0x60 clears it. After reset every line is in edge mode and every line is masked, so the CPU interrupt stays low until software writes the mask register.

Top module: `irq_front_end`

## Requirements
- R1: The implemented lines are 1, 3-7, 8, 9-11, 14 and 15 (implemented mask 0xCFFA). Input bits 0, 2, 12 and 13 never produce a pending bit, and those bit positions always read back as 0 in the mode and mask registers.
- R2: Line 8 is active low. A 0 on `reqIn[8]` is an active request, and a 1 is inactive. All other lines are active high.
- R3: While reset is active and right after it, the mode register reads 0x0000 (all lines edge mode) and the mask register reads 0xCFFA (all lines masked). `pending`, `cpuInt`, `keyLatch` and `ackValid` are all 0.
- R4: In edge mode (mode bit = 0), a rising edge of the synchronised active level sets the line's pending bit. The bit stays set after the line goes inactive, until an acknowledge clears it.
- R5: In level mode (mode bit = 1), the pending bit follows the synchronised active level and holds no memory.
- R6: `cpuInt` is 1 exactly when some pending line has its mask bit at 0 (mask bit 1 = masked).
- R7: A one-cycle `ackReq` makes `ackValid` go to 1 in the next cycle, with `ackLine` set to the lowest-numbered unmasked pending line whose input is still active. That line's edge capture is cleared.
- R8: `ackLine` is 7 in two cases: the lowest unmasked pending line is no longer active at the acknowledge, or no unmasked line is pending. A withdrawn line's edge capture is still cleared.
- R9: A rising edge on line 1 sets `keyLatch`, whatever the mode or mask. An `ioRd` with `ioAddr` = 0x60 clears it, and a read at any other address leaves it unchanged. A set and a clear in the same cycle leave it set.
- R10: Each input passes through a two-flop synchroniser. A level-mode change applied before one clock edge is not yet visible after that edge, and is visible after the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqIn | input | 16 | Raw asynchronous request lines, bit n = line n |
| modeWrEn | input | 1 | Write strobe for the mode register |
| modeWrData | input | 16 | Mode write data, 1 = level, 0 = edge |
| modeRd | output | 16 | Mode register read-back |
| maskWrEn | input | 1 | Write strobe for the mask register |
| maskWrData | input | 16 | Mask write data, 1 = masked |
| maskRd | output | 16 | Mask register read-back |
| ackReq | input | 1 | One-cycle acknowledge request |
| ackValid | output | 1 | Acknowledge result valid |
| ackLine | output | 4 | Acknowledged line number |
| ioRd | input | 1 | I/O read strobe |
| ioAddr | input | 16 | I/O read address |
| keyLatch | output | 1 | Line 1 rising-edge latch |
| pending | output | 16 | Pending request bits |
| cpuInt | output | 1 | CPU interrupt request |

## Verification
The bench pulses a line in edge mode and drops it before the acknowledge. A design without the withdrawn-request check would return 4 instead of 7 there, or would leave the stale capture pending. It runs acknowledges over several pending lines down to an empty set, which catches a priority encoder that picks the highest line, fails to clear the winner, or returns garbage when nothing is pending. It times a level-mode change edge by edge, so a one-flop or three-flop synchroniser is exposed. It also drives the inverted line 8 and the unimplemented bits: a polarity slip shows as a spurious pending bit, and a decoding slip in the key-latch clear shows when a read at 0x61 wipes the latch.

// File: rtl/irq_front_pkg.sv
package irq_front_pkg;
  localparam int NUM_LINES = 16;
  localparam int LINE_W = $clog2(NUM_LINES);

  // Strobes the control half sends to the datapath half
  typedef struct packed {
    logic [NUM_LINES-1:0] clrEdge;
    logic                 clrKey;
  } ctlStrobe_t;
endpackage

// File: rtl/irq_front_dp.sv
module irq_front_dp
  import irq_front_pkg::*;
#(
  parameter logic [NUM_LINES-1:0] IMPL_MASK   = 16'hCFFA,
  parameter logic [NUM_LINES-1:0] LOW_MASK    = 16'h0100,
  parameter int                   KEY_LINE    = 1,
  parameter int                   SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] reqIn,
  input  logic [NUM_LINES-1:0] modeLevel,
  input  ctlStrobe_t           strb,
  output logic [NUM_LINES-1:0] pendingOut,
  output logic [NUM_LINES-1:0] activeOut,
  output logic                 keyLatch
);
  logic [NUM_LINES-1:0] activeRaw;
  logic [NUM_LINES-1:0] syncStage [SYNC_STAGES];
  logic [NUM_LINES-1:0] syncd;
  logic [NUM_LINES-1:0] prevQ;
  logic [NUM_LINES-1:0] rise;
  logic [NUM_LINES-1:0] edgeQ;
  logic                 keyQ;

  // Polarity correction and removal of unimplemented lines
  assign activeRaw = (reqIn ^ LOW_MASK) & IMPL_MASK;

  // Synchroniser chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncStage[0] <= '0;
    else       syncStage[0] <= activeRaw;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncStage[s] <= '0;
      else       syncStage[s] <= syncStage[s-1];
    end
  end

  assign syncd = syncStage[SYNC_STAGES-1];

  // Edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= syncd;
  end

  assign rise = syncd & ~prevQ;

  // Edge capture: a new edge wins over a clear; level mode holds no capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) edgeQ <= '0;
    else       edgeQ <= ((edgeQ & ~strb.clrEdge) | rise) & ~modeLevel & IMPL_MASK;
  end

  // Keyboard-style latch, set wins over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) keyQ <= 1'b0;
    else       keyQ <= rise[KEY_LINE] | (keyQ & ~strb.clrKey);
  end

  assign pendingOut = ((modeLevel & syncd) | (~modeLevel & edgeQ)) & IMPL_MASK;
  assign activeOut  = syncd;
  assign keyLatch   = keyQ;
endmodule

// File: rtl/irq_front_ctl.sv
module irq_front_ctl
  import irq_front_pkg::*;
#(
  parameter logic [NUM_LINES-1:0] IMPL_MASK    = 16'hCFFA,
  parameter int                   ADDR_W       = 16,
  parameter logic [ADDR_W-1:0]    KEY_PORT     = 16'h0060,
  parameter int                   DEFAULT_LINE = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 modeWrEn,
  input  logic [NUM_LINES-1:0] modeWrData,
  input  logic                 maskWrEn,
  input  logic [NUM_LINES-1:0] maskWrData,
  input  logic                 ackReq,
  input  logic                 ioRd,
  input  logic [ADDR_W-1:0]    ioAddr,
  input  logic [NUM_LINES-1:0] pendingIn,
  input  logic [NUM_LINES-1:0] activeIn,
  output logic [NUM_LINES-1:0] modeQ,
  output logic [NUM_LINES-1:0] maskQ,
  output ctlStrobe_t           strb,
  output logic                 ackValid,
  output logic [LINE_W-1:0]    ackLine,
  output logic                 cpuInt
);
  logic [NUM_LINES-1:0] cand;
  logic                 found;
  logic [LINE_W-1:0]    win;
  logic                 withdrawn;
  logic [LINE_W-1:0]    ackNum;

  // Configuration registers, unimplemented bits held at zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= '0;
      maskQ <= IMPL_MASK;
    end else begin
      if (modeWrEn) modeQ <= modeWrData & IMPL_MASK;
      if (maskWrEn) maskQ <= maskWrData & IMPL_MASK;
    end
  end

  // Lowest-numbered unmasked pending line
  assign cand = pendingIn & ~maskQ;

  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        win   = LINE_W'(i);
      end
    end
  end

  assign withdrawn = found && !activeIn[win];
  assign ackNum    = (found && !withdrawn) ? win : LINE_W'(DEFAULT_LINE);

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) begin
      strb.clrEdge[i] = ackReq && found && (win == LINE_W'(i));
    end
    strb.clrKey = ioRd && (ioAddr == KEY_PORT);
  end

  // Acknowledge result register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackValid <= 1'b0;
      ackLine  <= '0;
    end else begin
      ackValid <= ackReq;
      if (ackReq) ackLine <= ackNum;
    end
  end

  assign cpuInt = |cand;
endmodule

// File: rtl/irq_front_end.sv
module irq_front_end
  import irq_front_pkg::*;
#(
  parameter logic [NUM_LINES-1:0] IMPL_MASK    = 16'hCFFA,
  parameter logic [NUM_LINES-1:0] LOW_MASK     = 16'h0100,
  parameter int                   KEY_LINE     = 1,
  parameter int                   SYNC_STAGES  = 2,
  parameter int                   ADDR_W       = 16,
  parameter logic [ADDR_W-1:0]    KEY_PORT     = 16'h0060,
  parameter int                   DEFAULT_LINE = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] reqIn,
  input  logic                 modeWrEn,
  input  logic [NUM_LINES-1:0] modeWrData,
  output logic [NUM_LINES-1:0] modeRd,
  input  logic                 maskWrEn,
  input  logic [NUM_LINES-1:0] maskWrData,
  output logic [NUM_LINES-1:0] maskRd,
  input  logic                 ackReq,
  output logic                 ackValid,
  output logic [LINE_W-1:0]    ackLine,
  input  logic                 ioRd,
  input  logic [ADDR_W-1:0]    ioAddr,
  output logic                 keyLatch,
  output logic [NUM_LINES-1:0] pending,
  output logic                 cpuInt
);
  ctlStrobe_t           strb;
  logic [NUM_LINES-1:0] activeLines;
  logic [NUM_LINES-1:0] modeQ;

  irq_front_dp #(
    .IMPL_MASK(IMPL_MASK), .LOW_MASK(LOW_MASK),
    .KEY_LINE(KEY_LINE), .SYNC_STAGES(SYNC_STAGES)
  ) dpI (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .modeLevel(modeQ), .strb(strb),
    .pendingOut(pending), .activeOut(activeLines), .keyLatch(keyLatch)
  );

  irq_front_ctl #(
    .IMPL_MASK(IMPL_MASK), .ADDR_W(ADDR_W),
    .KEY_PORT(KEY_PORT), .DEFAULT_LINE(DEFAULT_LINE)
  ) ctlI (
    .clk(clk), .rstN(rstN),
    .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .maskWrEn(maskWrEn), .maskWrData(maskWrData),
    .ackReq(ackReq), .ioRd(ioRd), .ioAddr(ioAddr),
    .pendingIn(pending), .activeIn(activeLines),
    .modeQ(modeQ), .maskQ(maskRd), .strb(strb),
    .ackValid(ackValid), .ackLine(ackLine), .cpuInt(cpuInt)
  );

  assign modeRd = modeQ;
endmodule

// File: rtl/irq_front_chk.sv
module irq_front_chk
  import irq_front_pkg::*;
#(
  parameter logic [NUM_LINES-1:0] IMPL_MASK    = 16'hCFFA,
  parameter int                   ADDR_W       = 16,
  parameter logic [ADDR_W-1:0]    KEY_PORT     = 16'h0060,
  parameter int                   DEFAULT_LINE = 7
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 ackReq,
  input logic                 ackValid,
  input logic [LINE_W-1:0]    ackLine,
  input logic                 ioRd,
  input logic [ADDR_W-1:0]    ioAddr,
  input logic                 keyLatch,
  input logic [NUM_LINES-1:0] pending,
  input logic [NUM_LINES-1:0] maskRd,
  input logic [NUM_LINES-1:0] modeRd,
  input logic                 cpuInt
);
  a_r1_unimpl_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ((pending | modeRd | maskRd) & ~IMPL_MASK) == '0);

  a_r6_masked_no_int: assert property (@(posedge clk) disable iff (!rstN)
    (maskRd == IMPL_MASK) |-> !cpuInt);

  a_r7_ack_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    ackReq |=> ackValid);

  a_r7_no_spurious_ack: assert property (@(posedge clk) disable iff (!rstN)
    !ackReq |=> !ackValid);

  a_r8_ack_line_legal: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> (ackLine == LINE_W'(DEFAULT_LINE) || IMPL_MASK[ackLine]));

  a_r9_key_holds: assert property (@(posedge clk) disable iff (!rstN)
    (keyLatch && !(ioRd && ioAddr == KEY_PORT)) |=> keyLatch);
endmodule

bind irq_front_end irq_front_chk #(
  .IMPL_MASK(IMPL_MASK), .ADDR_W(ADDR_W),
  .KEY_PORT(KEY_PORT), .DEFAULT_LINE(DEFAULT_LINE)
) chkI (
  .clk(clk), .rstN(rstN), .ackReq(ackReq), .ackValid(ackValid),
  .ackLine(ackLine), .ioRd(ioRd), .ioAddr(ioAddr), .keyLatch(keyLatch),
  .pending(pending), .maskRd(maskRd), .modeRd(modeRd), .cpuInt(cpuInt)
);

// File: tb/irq_front_end_tb_top.sv
`timescale 1ns/1ps
module irq_front_end_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] reqIn = 16'h0100;
  logic        modeWrEn = 1'b0;
  logic [15:0] modeWrData = '0;
  logic [15:0] modeRd;
  logic        maskWrEn = 1'b0;
  logic [15:0] maskWrData = '0;
  logic [15:0] maskRd;
  logic        ackReq = 1'b0;
  logic        ackValid;
  logic [3:0]  ackLine;
  logic        ioRd = 1'b0;
  logic [15:0] ioAddr = '0;
  logic        keyLatch;
  logic [15:0] pending;
  logic        cpuInt;

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  irq_front_end dut_i (
    .clk(clk), .rstN(rstN), .reqIn(reqIn),
    .modeWrEn(modeWrEn), .modeWrData(modeWrData), .modeRd(modeRd),
    .maskWrEn(maskWrEn), .maskWrData(maskWrData), .maskRd(maskRd),
    .ackReq(ackReq), .ackValid(ackValid), .ackLine(ackLine),
    .ioRd(ioRd), .ioAddr(ioAddr), .keyLatch(keyLatch),
    .pending(pending), .cpuInt(cpuInt)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog act=%0d exp=<20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  typedef struct packed {
    logic [15:0] mask;
    logic [15:0] req;
    logic [15:0] expPend;
    logic        expInt;
  } vec_t;

  // Level-mode vectors: R1 unimplemented bits, R2 line 8 polarity, R5, R6
  localparam vec_t VECS [6] = '{
    '{16'h0000, 16'h0100, 16'h0000, 1'b0},
    '{16'h0000, 16'h0102, 16'h0002, 1'b1},
    '{16'h0000, 16'h0000, 16'h0100, 1'b1},
    '{16'h0000, 16'h3105, 16'h0000, 1'b0},
    '{16'hC000, 16'hC188, 16'hC088, 1'b1},
    '{16'hC088, 16'hC188, 16'hC088, 1'b0}
  };

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic writeMode(logic [15:0] d);
    modeWrEn = 1'b1; modeWrData = d;
    tick(1);
    modeWrEn = 1'b0;
  endtask

  task automatic writeMask(logic [15:0] d);
    maskWrEn = 1'b1; maskWrData = d;
    tick(1);
    maskWrEn = 1'b0;
  endtask

  task automatic doAck(string tag, logic [3:0] expLine);
    ackReq = 1'b1;
    tick(1);
    ackReq = 1'b0;
    chk({tag, " ackValid"}, {15'd0, ackValid}, 16'd1);
    chk({tag, " ackLine"}, {12'd0, ackLine}, {12'd0, expLine});
  endtask

  initial begin
    tick(3);
    // R3 reset state, checked during reset and just after release
    chk("R3 pending in reset", pending, 16'h0000);
    chk("R3 cpuInt in reset", {15'd0, cpuInt}, 16'd0);
    rstN = 1'b1;
    tick(1);
    chk("R3 modeRd", modeRd, 16'h0000);
    chk("R3 maskRd", maskRd, 16'hCFFA);
    chk("R3 keyLatch", {15'd0, keyLatch}, 16'd0);
    chk("R3 ackValid", {15'd0, ackValid}, 16'd0);

    // R6: line 3 captured while all masked, no interrupt
    reqIn = 16'h0108;
    tick(4);
    chk("R6 pending masked", pending, 16'h0008);
    chk("R6 cpuInt masked", {15'd0, cpuInt}, 16'd0);
    reqIn = 16'h0100;

    // Vector table in level mode
    writeMode(16'hFFFF);
    chk("R1 modeRd unimpl zero", modeRd, 16'hCFFA);
    foreach (VECS[k]) begin
      writeMask(VECS[k].mask);
      reqIn = VECS[k].req;
      tick(4);
      chk($sformatf("R5/R6 vec%0d pending", k), pending, VECS[k].expPend);
      chk($sformatf("R6 vec%0d cpuInt", k), {15'd0, cpuInt}, {15'd0, VECS[k].expInt});
    end
    reqIn = 16'h0100;
    writeMask(16'h0000);
    chk("R1 maskRd", maskRd, 16'h0000);
    tick(4);

    // R10 two-flop latency
    reqIn = 16'h0120;
    tick(1);
    chk("R10 after one edge", pending, 16'h0000);
    tick(1);
    chk("R10 after two edges", pending, 16'h0020);
    reqIn = 16'h0100;
    tick(4);

    // R5 level following, no memory
    reqIn = 16'h0140;
    tick(4);
    chk("R5 level high", pending, 16'h0040);
    reqIn = 16'h0100;
    tick(4);
    chk("R5 level dropped", pending, 16'h0000);

    // R4 edge capture survives deassertion
    writeMode(16'h0000);
    tick(4);
    reqIn = 16'h0110;
    tick(4);
    reqIn = 16'h0100;
    tick(4);
    chk("R4 edge held", pending, 16'h0010);
    chk("R6 cpuInt unmasked", {15'd0, cpuInt}, 16'd1);

    // R7/R8 acknowledge sequence
    reqIn = 16'h0B00;
    tick(4);
    chk("R4 three pending", pending, 16'h0A10);
    doAck("R8 withdrawn line 4", 4'd7);
    chk("R8 withdrawn cleared", pending, 16'h0A00);
    doAck("R7 line 9", 4'd9);
    chk("R7 line 9 cleared", pending, 16'h0800);
    doAck("R7 line 11", 4'd11);
    chk("R7 all cleared", pending, 16'h0000);
    chk("R6 cpuInt idle", {15'd0, cpuInt}, 16'd0);
    doAck("R8 nothing pending", 4'd7);
    tick(1);
    chk("R7 ackValid drops", {15'd0, ackValid}, 16'd0);
    reqIn = 16'h0100;
    tick(4);

    // R9 key latch, independent of mask
    writeMask(16'hFFFF);
    reqIn = 16'h0102;
    tick(4);
    chk("R9 key set", {15'd0, keyLatch}, 16'd1);
    reqIn = 16'h0100;
    ioRd = 1'b1; ioAddr = 16'h0061;
    tick(1);
    chk("R9 other address ignored", {15'd0, keyLatch}, 16'd1);
    ioAddr = 16'h0060;
    tick(1);
    ioRd = 1'b0;
    chk("R9 read 0x60 clears", {15'd0, keyLatch}, 16'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule